// File: doc/BRIEF.md
# Circular Read Queue on Handshaked External Static RAM

This block keeps a first-in, first-out byte queue inside a window of an external static RAM instead of an on-chip FIFO. A consumer talks to it through three one-cycle method strobes: an emptiness query, an occupancy query and a pop. Every accepted method finishes with a one-cycle completion pulse. A pop also returns the byte that was removed, and a query returns its answer on the result outputs. A producer fills the queue through a push port with a valid/ready handshake.

Each memory access is a transaction on a request/acknowledge handshake. The block drives a 16-bit address (a base offset plus a slot index), and for a write it also drives the write data and a write enable. It holds the request until the memory acknowledges. Two registered pointers, each one bit wider than the slot index, mark the oldest and the next free slot. The extra bit tells a full queue from an empty one. A small sequencer lets only one transaction own the memory at a time.

Top module: `rbuf_sram_queue`

## Requirements
- R1: After synchronous reset the queue is empty. `res_done`, `res_err` and `mem_req` are 0, `res_data` and `res_count` are 0, and `res_empty` is 1.
- R2: An emptiness query completes one cycle after its strobe is sampled. `res_done` is 1 in that cycle, and `res_empty` is 1 exactly when the queue holds no bytes.
- R3: An occupancy query completes one cycle after its strobe is sampled. `res_count` (DEPTH_LOG2+1 bits) then holds the number of stored bytes, from 0 to 2**DEPTH_LOG2. A full queue reads as 2**DEPTH_LOG2 with `res_empty` 0, which is distinct from an empty one.
- R4: A pop on a non-empty queue raises `mem_req` with `mem_we`=0 and holds request and address steady until `mem_ack`. It captures `mem_rdata` on the acknowledge cycle and pulses `res_done` for one cycle in the next cycle with that byte on `res_data`. Bytes come out in push order, and with an acknowledge L cycles after the request rises, `res_done` appears L+2 cycles after the strobe is driven.
- R5: Every memory access uses address BASE_ADDR + slot. Reads use the oldest slot and writes use the next free slot, and both slot indices wrap modulo 2**DEPTH_LOG2.
- R6: A pop on an empty queue issues no memory read and pulses `res_done` one cycle later. `res_data` keeps its previous value.
- R7: A push raises `mem_req` with `mem_we`=1, the next free slot's address and `push_data`, and holds them until `mem_ack`. `push_ready` is 1 in the acknowledge cycle. A push offered while the queue is full waits with no memory request until a slot frees.
- R8: When a pop strobe and a pending push meet in an idle cycle, the pop takes the memory first, and the push is stalled until the pop's transaction completes.
- R9: Method strobes sampled while a memory transaction is in progress are ignored and produce no completion. When several strobes arrive together, only one is taken, with priority pop over occupancy over emptiness.
- R10: `res_err` is 1 only in the completion cycle of a pop on an empty queue and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_empty_stb | input | 1 | Emptiness query strobe |
| q_size_stb | input | 1 | Occupancy query strobe |
| q_pop_stb | input | 1 | Pop strobe |
| res_data | output | 8 | Byte returned by the last successful pop |
| res_count | output | DEPTH_LOG2+1 | Occupancy returned by the last query |
| res_empty | output | 1 | Emptiness returned by the last query |
| res_err | output | 1 | Pop-on-empty indication, valid with res_done |
| res_done | output | 1 | One-cycle method completion pulse |
| push_valid | input | 1 | Producer offers a byte |
| push_data | input | 8 | Byte to store, held while push_valid is 1 |
| push_ready | output | 1 | Byte written to memory this cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write enable, valid with mem_req |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with acknowledge |

## Verification
The bench fills the queue to exactly full, offers one more byte and drains it, so both pointers cross the wrap point. A design that compared only the slot bits would call the full queue empty, report an occupancy of 0, or overwrite the oldest byte. Pops on an empty queue check that no read starts, that the returned byte does not change and that the error flag appears only in that completion. A pop that collides with a push, and strobes issued while a slow read is outstanding, expose a sequencer that lets the write jump ahead, answers a query twice, or drops the pop. Acknowledge latencies of 0 to 3 cycles check that the request stays up and the address stays still until acknowledge, and that the completion lands exactly two cycles after the latency.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_POP   = 2'd1,
        OP_SIZE  = 2'd2,
        OP_EMPTY = 2'd3
    } method_e;

    typedef struct packed {
        byte_t data;
        logic  empty;
        logic  err;
        logic  done;
    } result_t;

    // Pop outranks the occupancy query, which outranks the emptiness query.
    function automatic method_e pick_method(input logic pop, input logic size, input logic empty);
        if (pop)   return OP_POP;
        if (size)  return OP_SIZE;
        if (empty) return OP_EMPTY;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/rb_ptrs.sv
module rb_ptrs #(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv_head,
    input  logic                  adv_tail,
    output logic [DEPTH_LOG2-1:0] head_idx,
    output logic [DEPTH_LOG2-1:0] tail_idx,
    output logic [DEPTH_LOG2:0]   occupancy,
    output logic                  is_empty,
    output logic                  is_full
);
    localparam int            PW      = DEPTH_LOG2 + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(1) << DEPTH_LOG2;

    // One wrap bit above the slot index separates full from empty.
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (adv_head) head_q <= head_q + 1'b1;
            if (adv_tail) tail_q <= tail_q + 1'b1;
        end
    end

    assign head_idx  = head_q[DEPTH_LOG2-1:0];
    assign tail_idx  = tail_q[DEPTH_LOG2-1:0];
    assign occupancy = tail_q - head_q;
    assign is_empty  = (head_q == tail_q);
    assign is_full   = (head_q[DEPTH_LOG2] != tail_q[DEPTH_LOG2]) &&
                       (head_idx == tail_idx);

    p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
        occupancy <= DEPTH_V)
        else $error("occupancy above depth");

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        adv_head |-> !is_empty)
        else $error("read completed on empty queue");

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        adv_tail |-> !is_full)
        else $error("write completed on full queue");

endmodule

// File: rtl/rb_addr_map.sv
module rb_addr_map #(
    parameter int          ADDR_W     = 16,
    parameter int          DEPTH_LOG2 = 4,
    parameter int unsigned BASE_ADDR  = 256
) (
    input  logic [DEPTH_LOG2-1:0] slot,
    output logic [ADDR_W-1:0]     addr
);
    generate
        if (DEPTH_LOG2 >= ADDR_W) begin : g_whole_space
            assign addr = slot[ADDR_W-1:0];
        end else begin : g_window
            localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
            assign addr = BASE_V + ADDR_W'(slot);
        end
    endgenerate
endmodule

// File: rtl/rb_seq.sv
module rb_seq
    import rbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  method_e method,
    input  logic    push_valid,
    input  logic    is_empty,
    input  logic    is_full,
    input  logic    mem_ack,
    output logic    mem_req,
    output logic    mem_we,
    output logic    wr_phase,
    output logic    rd_fin,
    output logic    wr_fin,
    output logic    query_take,
    output logic    empty_pop
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        rd_fin     = 1'b0;
        wr_fin     = 1'b0;
        query_take = 1'b0;
        empty_pop  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (method == OP_POP) begin
                    // A pop claims the cycle; any offered push waits.
                    if (is_empty) empty_pop = 1'b1;
                    else          state_d   = ST_READ;
                end else begin
                    if (method != OP_NONE)       query_take = 1'b1;
                    if (push_valid && !is_full) state_d    = ST_WRITE;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    rd_fin  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    wr_fin  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wr_phase = (state_q == ST_WRITE);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req)
        else $error("request dropped before acknowledge");

    p_we_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_we == $past(mem_we)))
        else $error("direction changed inside a transaction");

    p_empty_pop_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        empty_pop |=> !(mem_req && !mem_we))
        else $error("read started for a pop on an empty queue");

endmodule

// File: rtl/rb_result.sv
module rb_result
    import rbuf_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_fin,
    input  byte_t               rd_byte,
    input  logic                query_take,
    input  logic                empty_pop,
    input  logic [DEPTH_LOG2:0] occupancy,
    input  logic                is_empty,
    output byte_t               res_data,
    output logic [DEPTH_LOG2:0] res_count,
    output logic                res_empty,
    output logic                res_err,
    output logic                res_done
);
    result_t             r_q;
    logic [DEPTH_LOG2:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '{data: '0, empty: 1'b1, err: 1'b0, done: 1'b0};
            cnt_q <= '0;
        end else begin
            r_q.done <= rd_fin | query_take | empty_pop;
            r_q.err  <= empty_pop;
            if (rd_fin) r_q.data <= rd_byte;
            if (query_take) begin
                r_q.empty <= is_empty;
                cnt_q     <= occupancy;
            end
        end
    end

    assign res_data  = r_q.data;
    assign res_empty = r_q.empty;
    assign res_err   = r_q.err;
    assign res_done  = r_q.done;
    assign res_count = cnt_q;

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        res_err |-> res_done)
        else $error("error flag outside a completion");

    p_data_held_r6: assert property (@(posedge clk) disable iff (rst)
        empty_pop |=> $stable(res_data))
        else $error("result byte changed on an empty pop");

endmodule

// File: rtl/rbuf_sram_queue.sv
module rbuf_sram_queue
    import rbuf_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DEPTH_LOG2 = 4,
    parameter int unsigned BASE_ADDR  = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  q_empty_stb,
    input  logic                  q_size_stb,
    input  logic                  q_pop_stb,
    output logic [7:0]            res_data,
    output logic [DEPTH_LOG2:0]   res_count,
    output logic                  res_empty,
    output logic                  res_err,
    output logic                  res_done,
    input  logic                  push_valid,
    input  logic [7:0]            push_data,
    output logic                  push_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  mem_we,
    output logic                  mem_req,
    input  logic                  mem_ack,
    input  logic [7:0]            mem_rdata
);
    method_e               method;
    logic                  rd_fin, wr_fin, query_take, empty_pop, wr_phase;
    logic [DEPTH_LOG2-1:0] head_idx, tail_idx, slot;
    logic [DEPTH_LOG2:0]   occupancy;
    logic                  is_empty, is_full;

    assign method = pick_method(q_pop_stb, q_size_stb, q_empty_stb);

    rb_ptrs #(.DEPTH_LOG2(DEPTH_LOG2)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .adv_head  (rd_fin),
        .adv_tail  (wr_fin),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .occupancy (occupancy),
        .is_empty  (is_empty),
        .is_full   (is_full)
    );

    rb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .method     (method),
        .push_valid (push_valid),
        .is_empty   (is_empty),
        .is_full    (is_full),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .wr_phase   (wr_phase),
        .rd_fin     (rd_fin),
        .wr_fin     (wr_fin),
        .query_take (query_take),
        .empty_pop  (empty_pop)
    );

    assign slot = wr_phase ? tail_idx : head_idx;

    rb_addr_map #(
        .ADDR_W     (ADDR_W),
        .DEPTH_LOG2 (DEPTH_LOG2),
        .BASE_ADDR  (BASE_ADDR)
    ) u_map (
        .slot (slot),
        .addr (mem_addr)
    );

    rb_result #(.DEPTH_LOG2(DEPTH_LOG2)) u_res (
        .clk        (clk),
        .rst        (rst),
        .rd_fin     (rd_fin),
        .rd_byte    (mem_rdata),
        .query_take (query_take),
        .empty_pop  (empty_pop),
        .occupancy  (occupancy),
        .is_empty   (is_empty),
        .res_data   (res_data),
        .res_count  (res_count),
        .res_empty  (res_empty),
        .res_err    (res_err),
        .res_done   (res_done)
    );

    assign mem_wdata  = push_data;
    assign push_ready = wr_fin;

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr))
        else $error("address moved during a transaction");

    p_push_waits_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !push_ready)
        else $error("push completed while a read owned memory");

endmodule

// File: tb/test_rbuf_sram_queue.sv
`timescale 1ns/1ps
module test_rbuf_sram_queue;
    localparam int AW    = 16;
    localparam int DL    = 4;
    localparam int DEPTH = 16;
    localparam int BASE  = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          q_empty_stb = 1'b0, q_size_stb = 1'b0, q_pop_stb = 1'b0;
    logic [7:0]    res_data;
    logic [DL:0]   res_count;
    logic          res_empty, res_err, res_done;
    logic          push_valid = 1'b0;
    logic [7:0]    push_data = 8'h00;
    logic          push_ready;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we, mem_req;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = 8'h00;

    rbuf_sram_queue #(.ADDR_W(AW), .DEPTH_LOG2(DL), .BASE_ADDR(BASE)) i_rbuf_sram_queue (
        .clk(clk), .rst(rst),
        .q_empty_stb(q_empty_stb), .q_size_stb(q_size_stb), .q_pop_stb(q_pop_stb),
        .res_data(res_data), .res_count(res_count), .res_empty(res_empty),
        .res_err(res_err), .res_done(res_done),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;
    int lat = 0, ack_cnt = 0, exp_addr = 0;
    int head_m = 0, tail_m = 0, dones = 0, cyc = 0;
    logic [7:0] q[$];
    logic [7:0] sram [DEPTH];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Memory model: acknowledge after lat waiting cycles, check every address (R5).
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            ack_cnt = 0;
        end else if (mem_req) begin
            if (ack_cnt >= lat) begin
                exp_addr = BASE + ((mem_we ? tail_m : head_m) % DEPTH);
                chk(int'(mem_addr) == exp_addr, "R5 access address", int'(mem_addr), exp_addr);
                if (mem_we) sram[mem_addr[DL-1:0]] = mem_wdata;
                else        mem_rdata <= sram[mem_addr[DL-1:0]];
                mem_ack <= 1'b1;
            end else begin
                ack_cnt++;
            end
        end
    end

    // Per-clock monitor: completion count, error flag rule (R10), watchdog.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            if (res_done) dones++;
            chk(!(res_err && !res_done), "R10 error outside completion", int'(res_err), 0);
        end
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic query(input bit size_q);
        @(negedge clk);
        if (size_q) q_size_stb = 1'b1; else q_empty_stb = 1'b1;
        @(negedge clk);
        q_size_stb = 1'b0; q_empty_stb = 1'b0;
        #2;
        if (size_q) begin
            chk(res_done, "R3 size completes in one cycle", int'(res_done), 1);
            chk(int'(res_count) == q.size(), "R3 occupancy", int'(res_count), q.size());
        end else begin
            chk(res_done, "R2 empty completes in one cycle", int'(res_done), 1);
            chk(res_empty == (q.size() == 0), "R2 empty answer", int'(res_empty), int'(q.size() == 0));
        end
    endtask

    task automatic do_pop();
        int n;
        logic [7:0] prev;
        logic [7:0] ev;
        prev = res_data;
        @(negedge clk);
        q_pop_stb = 1'b1;
        @(negedge clk);
        q_pop_stb = 1'b0;
        #2;
        n = 1;
        while (!res_done && n < 60) begin tick(); n++; end
        if (q.size() == 0) begin
            chk(n == 1, "R6 empty pop completes next cycle", n, 1);
            chk(res_err, "R6 R10 error on empty pop", int'(res_err), 1);
            chk(res_data == prev, "R6 data held", int'(res_data), int'(prev));
        end else begin
            ev = q.pop_front();
            head_m++;
            chk(n == 2 + lat, "R4 pop completion cycle", n, 2 + lat);
            chk(res_data == ev, "R4 pop byte order", int'(res_data), int'(ev));
            chk(!res_err, "R10 no error on good pop", int'(res_err), 0);
        end
        tick();
        chk(!res_done, "R4 completion is one pulse", int'(res_done), 0);
    endtask

    task automatic wait_push(input logic [7:0] d, input int exp_n);
        int n;
        n = 0;
        do begin tick(); n++; end while (!push_ready && n < 60);
        if (exp_n > 0) chk(n == exp_n, "R7 push acknowledge cycle", n, exp_n);
        chk(push_ready, "R7 push accepted", int'(push_ready), 1);
        @(negedge clk);
        push_valid = 1'b0;
        q.push_back(d);
        tail_m++;
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = d;
        wait_push(d, 1 + lat);
    endtask

    initial begin
        int d0;
        logic [DL:0] prev_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!res_done && !res_err && !mem_req, "R1 reset controls", int'({res_done, res_err, mem_req}), 0);
        chk(res_data == 8'h00 && res_count == '0, "R1 reset results", int'(res_data), 0);
        chk(res_empty, "R1 reset empty flag", int'(res_empty), 1);
        query(1'b1);
        query(1'b0);

        do_pop();                          // R6 on empty

        lat = 0;
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        query(1'b1);
        query(1'b0);
        lat = 2;
        do_pop();
        do_pop();
        lat = 1;
        do_push(8'h44);
        do_pop(); do_pop();
        do_pop();                          // empty again, R6

        // Fill to full across the slot wrap (R3, R5, R7).
        for (int i = 0; i < DEPTH; i++) do_push(8'h80 + 8'(i));
        query(1'b1);
        query(1'b0);
        chk(int'(res_count) == DEPTH && !res_empty, "R3 full differs from empty", int'(res_count), DEPTH);

        // Push while full stalls without memory traffic (R7).
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = 8'hA5;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!mem_req, "R7 full push waits", int'(mem_req), 0);
        end
        do_pop();
        wait_push(8'hA5, 0);
        query(1'b1);

        // Pop and push meet in an idle cycle: read goes first (R8).
        lat = 2;
        @(negedge clk);
        q_pop_stb  = 1'b1;
        push_valid = 1'b1;
        push_data  = 8'h5A;
        @(negedge clk);
        q_pop_stb = 1'b0;
        #2;
        chk(mem_req && !mem_we, "R8 pop owns memory first", int'({mem_req, mem_we}), 2);
        begin
            int n;
            logic [7:0] ev;
            n = 0;
            while (!res_done && n < 60) begin tick(); n++; end
            ev = q.pop_front();
            head_m++;
            chk(res_data == ev, "R8 pop byte", int'(res_data), int'(ev));
        end
        wait_push(8'h5A, 0);
        query(1'b1);

        // Strobes during an outstanding read are ignored (R9).
        lat = 3;
        d0 = dones;
        @(negedge clk); q_pop_stb = 1'b1;
        @(negedge clk); q_pop_stb = 1'b0; q_size_stb = 1'b1;
        @(negedge clk); q_size_stb = 1'b0; q_empty_stb = 1'b1;
        @(negedge clk); q_empty_stb = 1'b0;
        begin
            int n;
            logic [7:0] ev;
            n = 0;
            #2;
            while (!res_done && n < 60) begin tick(); n++; end
            ev = q.pop_front();
            head_m++;
            chk(res_data == ev, "R9 pop byte under busy strobes", int'(res_data), int'(ev));
        end
        repeat (3) tick();
        chk(dones - d0 == 1, "R9 busy strobes ignored", dones - d0, 1);
        query(1'b1);

        // Simultaneous strobes: only the pop is taken (R9).
        prev_cnt = res_count;
        d0 = dones;
        @(negedge clk);
        q_pop_stb = 1'b1; q_size_stb = 1'b1; q_empty_stb = 1'b1;
        @(negedge clk);
        q_pop_stb = 1'b0; q_size_stb = 1'b0; q_empty_stb = 1'b0;
        begin
            int n;
            logic [7:0] ev;
            n = 1;
            #2;
            while (!res_done && n < 60) begin tick(); n++; end
            ev = q.pop_front();
            head_m++;
            chk(n == 2 + lat, "R9 pop wins priority", n, 2 + lat);
            chk(res_data == ev, "R9 priority pop byte", int'(res_data), int'(ev));
            chk(res_count == prev_cnt, "R9 size not taken", int'(res_count), int'(prev_cnt));
        end
        repeat (3) tick();
        chk(dones - d0 == 1, "R9 single completion", dones - d0, 1);

        lat = 0;
        while (q.size() > 0) do_pop();
        do_pop();
        query(1'b0);
        query(1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule